// File: doc/BRIEF.md
# Blank-Check Range Scanner

This block reads a contiguous run of memory words, one at a time, and tests each word against a constant. The constant is either every bit low or every bit high. A typical use is to confirm that a region is blank after an erase, or that it was fully programmed. Before a scan, software loads a base word address and a word count, which are held in internal registers. It then pulses the start input and supplies three values with it: a region code, the pattern choice and a halt-on-mismatch option. The scanner takes a copy of these three at that moment.

The memory side is a plain request/response port. The scanner raises `rd_req_o` for one cycle with a region code and a word address. It then waits for `rd_valid_i`, so only one read is ever outstanding. During the scan the block counts mismatching words, with saturation, and keeps the address of the first one. Two error bits record whether a mismatch was seen and whether the scan stopped on an address outside the region. A two-bit status code and a completion flag are visible at all times, and the finished state holds until software clears it.

Top module: `blank_check_engine`

## Requirements
- R1: The status code is 0 for idle, 1 for pending, 2 for scanning and 3 for finished. A start pulse accepted in cycle k gives status 1 after edge k and status 2 after edge k+1. A start pulse is accepted only when the status is 0 or 3.
- R2: A scan of N words reads addresses base, base+1, … in order, with exactly one request per word and one outstanding read. With a one-cycle memory and no halt, status 3 appears 2N+3 edges after the start edge (the start edge counted as the first).
- R3: Pattern 0 expects a word of all zeros and pattern 1 expects all ones. The compare-error bit is set when any word read in the scan differs from the expected word.
- R4: The fail count equals the number of mismatching words. It stops at 2^CNT_W−1 instead of wrapping, and is reset to 0 when a start is accepted.
- R5: The fail address holds the address of the first mismatching word of the scan, and is 0 when there is none.
- R6: With halt-on-mismatch set, the scan ends right after the first mismatching read, and status 3 appears 2R+2 edges after the start edge, where R is the number of reads made.
- R7: The region code is 0 for main, 1 for information, 3 for engineering and 2 for invalid. The sizes are MAIN_WORDS, INFO_WORDS and ENG_WORDS, and the invalid region has size 0. When the next address is not below the region size, the scan ends with the address-error bit set and no read is made for that address.
- R8: A word count of 0 ends the scan with status 3 three edges after the start edge, with no reads and both error bits clear.
- R9: Status 3 holds until a clear pulse. A clear pulse returns the status to 0 and clears both error bits and the completion flag on the next edge, whatever the state.
- R10: Writes to the base and count registers, and start pulses, have no effect while the status is 1 or 2.
- R11: The completion flag rises on the same edge on which the status becomes 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; takes a copy of region, pattern and halt |
| clear_i | input | 1 | Clears status, error bits and completion flag |
| region_i | input | 2 | Region code for the scan |
| pattern_i | input | 1 | 0: expect all zeros, 1: expect all ones |
| halt_i | input | 1 | Stop at the first mismatch |
| base_we_i | input | 1 | Write enable for the base register |
| base_i | input | ADDR_W | Base word address |
| count_we_i | input | 1 | Write enable for the count register |
| count_i | input | LEN_W | Number of words to scan |
| rd_req_o | output | 1 | Read request, one cycle per word |
| rd_region_o | output | 2 | Region of the requested word |
| rd_addr_o | output | ADDR_W | Address of the requested word |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data |
| status_o | output | 2 | Status code |
| cmp_err_o | output | 1 | At least one mismatch seen |
| addr_err_o | output | 1 | Scan ended on an out-of-region address |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_cnt_o | output | CNT_W | Saturating count of mismatches |
| done_flag_o | output | 1 | Completion flag |

## Verification
Every result has a fixed arrival cycle, counted in edges from the start edge. Pending shows after the first edge and scanning after the second. A one-cycle memory costs two edges per word. The finished code arrives at 2R+3 edges, or at 2R+2 when the halt option ends the scan, and the completion flag, counters and error bits are valid in that same sample. The bench samples only on falling edges and counts the edges until status 3 appears. It compares that count with the latency it computes from its own walk over its memory image, and compares the number of requests seen at the port with the number of reads that walk predicts.

// File: rtl/blank_check_pkg.sv
package blank_check_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PEND  = 3'd1,
        S_ISSUE = 3'd2,
        S_WAIT  = 3'd3,
        S_DONE  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        STAT_IDLE = 2'd0,
        STAT_PEND = 2'd1,
        STAT_RUN  = 2'd2,
        STAT_FIN  = 2'd3
    } status_e;

    localparam logic [1:0] RGN_MAIN = 2'd0;
    localparam logic [1:0] RGN_INFO = 2'd1;
    localparam logic [1:0] RGN_BAD  = 2'd2;
    localparam logic [1:0] RGN_ENG  = 2'd3;

endpackage

// File: rtl/bce_region_guard.sv
module bce_region_guard
    import blank_check_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MAIN_WORDS = 4096,
    parameter int INFO_WORDS = 256,
    parameter int ENG_WORDS  = 64
) (
    input  logic [1:0]      region_i,
    input  logic [ADDR_W:0] addr_i,
    output logic            legal_o
);
    localparam int AW1 = ADDR_W + 1;
    localparam logic [AW1-1:0] MAIN_END = AW1'(MAIN_WORDS);
    localparam logic [AW1-1:0] INFO_END = AW1'(INFO_WORDS);
    localparam logic [AW1-1:0] ENG_END  = AW1'(ENG_WORDS);

    always_comb begin
        unique case (region_i)
            RGN_MAIN: legal_o = addr_i < MAIN_END;
            RGN_INFO: legal_o = addr_i < INFO_END;
            RGN_ENG:  legal_o = addr_i < ENG_END;
            default:  legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bce_miss_tally.sv
module bce_miss_tally #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              miss_i,
    input  logic [ADDR_W-1:0] miss_addr_i,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [CNT_W-1:0]  fail_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] faddr;
        logic [CNT_W-1:0]  cnt;
    } tally_t;

    tally_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.faddr = '0;
            d.cnt   = '0;
        end else if (miss_i) begin
            if (q.cnt == '0) begin
                d.faddr = miss_addr_i;
            end
            if (q.cnt != CNT_MAX) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fail_addr_o = q.faddr;
    assign fail_cnt_o  = q.cnt;
endmodule

// File: rtl/bce_sequencer.sv
module bce_sequencer
    import blank_check_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clear_i,
    input  logic [1:0]        region_i,
    input  logic              pattern_i,
    input  logic              halt_i,
    input  logic              base_we_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              count_we_i,
    input  logic [LEN_W-1:0]  count_i,
    input  logic              legal_i,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W:0]   cur_addr_o,
    output logic [1:0]        region_o,
    output logic [1:0]        status_o,
    output logic              cmp_err_o,
    output logic              addr_err_o,
    output logic              done_o,
    output logic              tally_clr_o,
    output logic              miss_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  count;
        logic [ADDR_W:0]   cur;
        logic [LEN_W-1:0]  remain;
        logic [1:0]        region;
        logic              pattern;
        logic              halt;
        logic              cmp_err;
        logic              addr_err;
        logic              done;
    } seq_t;

    seq_t d, q;
    logic busy;
    logic mismatch;

    assign busy     = (q.st == S_PEND) || (q.st == S_ISSUE) || (q.st == S_WAIT);
    assign mismatch = rd_data_i != {DATA_W{q.pattern}};

    always_comb begin
        d           = q;
        tally_clr_o = 1'b0;
        miss_o      = 1'b0;

        if (base_we_i && !busy) begin
            d.base = base_i;
        end
        if (count_we_i && !busy) begin
            d.count = count_i;
        end

        if (clear_i) begin
            d.st       = S_IDLE;
            d.cmp_err  = 1'b0;
            d.addr_err = 1'b0;
            d.done     = 1'b0;
        end else begin
            unique case (q.st)
                S_IDLE, S_DONE: begin
                    if (start_i) begin
                        d.st        = S_PEND;
                        d.cur       = {1'b0, q.base};
                        d.remain    = q.count;
                        d.region    = region_i;
                        d.pattern   = pattern_i;
                        d.halt      = halt_i;
                        d.cmp_err   = 1'b0;
                        d.addr_err  = 1'b0;
                        d.done      = 1'b0;
                        tally_clr_o = 1'b1;
                    end
                end
                S_PEND: begin
                    d.st = S_ISSUE;
                end
                S_ISSUE: begin
                    if (q.remain == '0) begin
                        d.st   = S_DONE;
                        d.done = 1'b1;
                    end else if (!legal_i) begin
                        d.st       = S_DONE;
                        d.addr_err = 1'b1;
                        d.done     = 1'b1;
                    end else begin
                        d.st = S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (rd_valid_i) begin
                        if (mismatch) begin
                            d.cmp_err = 1'b1;
                            miss_o    = 1'b1;
                        end
                        if (mismatch && q.halt) begin
                            d.st   = S_DONE;
                            d.done = 1'b1;
                        end else begin
                            d.cur    = q.cur + 1'b1;
                            d.remain = q.remain - 1'b1;
                            d.st     = S_ISSUE;
                        end
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            S_PEND:          status_o = STAT_PEND;
            S_ISSUE, S_WAIT: status_o = STAT_RUN;
            S_DONE:          status_o = STAT_FIN;
            default:         status_o = STAT_IDLE;
        endcase
    end

    assign rd_req_o   = (q.st == S_ISSUE) && (q.remain != '0) && legal_i && !clear_i;
    assign cur_addr_o = q.cur;
    assign region_o   = q.region;
    assign cmp_err_o  = q.cmp_err;
    assign addr_err_o = q.addr_err;
    assign done_o     = q.done;
endmodule

// File: rtl/blank_check_engine.sv
module blank_check_engine
    import blank_check_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 8,
    parameter int MAIN_WORDS = 4096,
    parameter int INFO_WORDS = 256,
    parameter int ENG_WORDS  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clear_i,
    input  logic [1:0]        region_i,
    input  logic              pattern_i,
    input  logic              halt_i,
    input  logic              base_we_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              count_we_i,
    input  logic [LEN_W-1:0]  count_i,
    output logic              rd_req_o,
    output logic [1:0]        rd_region_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [1:0]        status_o,
    output logic              cmp_err_o,
    output logic              addr_err_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [CNT_W-1:0]  fail_cnt_o,
    output logic              done_flag_o
);
    logic            legal;
    logic [ADDR_W:0] cur_addr;
    logic            tally_clr;
    logic            miss;

    bce_sequencer #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .clear_i     (clear_i),
        .region_i    (region_i),
        .pattern_i   (pattern_i),
        .halt_i      (halt_i),
        .base_we_i   (base_we_i),
        .base_i      (base_i),
        .count_we_i  (count_we_i),
        .count_i     (count_i),
        .legal_i     (legal),
        .rd_valid_i  (rd_valid_i),
        .rd_data_i   (rd_data_i),
        .rd_req_o    (rd_req_o),
        .cur_addr_o  (cur_addr),
        .region_o    (rd_region_o),
        .status_o    (status_o),
        .cmp_err_o   (cmp_err_o),
        .addr_err_o  (addr_err_o),
        .done_o      (done_flag_o),
        .tally_clr_o (tally_clr),
        .miss_o      (miss)
    );

    bce_region_guard #(
        .ADDR_W     (ADDR_W),
        .MAIN_WORDS (MAIN_WORDS),
        .INFO_WORDS (INFO_WORDS),
        .ENG_WORDS  (ENG_WORDS)
    ) i_guard (
        .region_i (rd_region_o),
        .addr_i   (cur_addr),
        .legal_o  (legal)
    );

    bce_miss_tally #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_tally (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (tally_clr),
        .miss_i      (miss),
        .miss_addr_i (cur_addr[ADDR_W-1:0]),
        .fail_addr_o (fail_addr_o),
        .fail_cnt_o  (fail_cnt_o)
    );

    assign rd_addr_o = cur_addr[ADDR_W-1:0];
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             clear_i,
    input logic             rd_req_o,
    input logic [1:0]       status_o,
    input logic             cmp_err_o,
    input logic [CNT_W-1:0] fail_cnt_o,
    input logic             done_flag_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_pend_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd1 && !clear_i) |=> (status_o == 2'd2));

    p_req_in_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (status_o == 2'd2));

    p_err_has_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err_o |-> (fail_cnt_o != '0));

    p_count_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o == CNT_MAX && !(start_i && !clear_i && (status_o == 2'd0 || status_o == 2'd3)))
        |=> (fail_cnt_o == CNT_MAX));

    p_fin_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd3 && !clear_i && !start_i) |=> (status_o == 2'd3));

    p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (status_o == 2'd0 && !cmp_err_o && !done_flag_o));

    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd2 && !clear_i) |=> (status_o != 2'd1));

    p_flag_at_fin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag_o) |-> (status_o == 2'd3));
endmodule

bind blank_check_engine bce_checker #(.CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .clear_i     (clear_i),
    .rd_req_o    (rd_req_o),
    .status_o    (status_o),
    .cmp_err_o   (cmp_err_o),
    .fail_cnt_o  (fail_cnt_o),
    .done_flag_o (done_flag_o)
);

// File: tb/test_blank_check_engine.sv
module test_blank_check_engine;
    localparam int CLK_P = 10;
    localparam int AW    = 8;
    localparam int LW    = 8;
    localparam int DW    = 8;
    localparam int CW    = 4;
    localparam int MAINW = 64;
    localparam int INFOW = 16;
    localparam int ENGW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [1:0]    region_i = '0;
    logic          pattern_i = 1'b0;
    logic          halt_i = 1'b0;
    logic          base_we_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic          count_we_i = 1'b0;
    logic [LW-1:0] count_i = '0;
    logic          rd_req_o;
    logic [1:0]    rd_region_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic [1:0]    status_o;
    logic          cmp_err_o;
    logic          addr_err_o;
    logic [AW-1:0] fail_addr_o;
    logic [CW-1:0] fail_cnt_o;
    logic          done_flag_o;

    logic [DW-1:0] mem [0:3][0:63];
    int            nchk = 0;
    int            nfail = 0;
    int            reads_seen = 0;

    int e_reads, e_cnt, e_faddr, e_cmp, e_aerr, e_halt, e_lat;

    always #(CLK_P/2) clk = ~clk;

    blank_check_engine #(
        .ADDR_W(AW), .LEN_W(LW), .DATA_W(DW), .CNT_W(CW),
        .MAIN_WORDS(MAINW), .INFO_WORDS(INFOW), .ENG_WORDS(ENGW)
    ) i_blank_check_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
        .region_i(region_i), .pattern_i(pattern_i), .halt_i(halt_i),
        .base_we_i(base_we_i), .base_i(base_i), .count_we_i(count_we_i), .count_i(count_i),
        .rd_req_o(rd_req_o), .rd_region_o(rd_region_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .status_o(status_o), .cmp_err_o(cmp_err_o), .addr_err_o(addr_err_o),
        .fail_addr_o(fail_addr_o), .fail_cnt_o(fail_cnt_o), .done_flag_o(done_flag_o)
    );

    // one-cycle memory model
    always @(posedge clk) begin
        rd_valid_i <= rd_req_o;
        rd_data_i  <= mem[rd_region_o][rd_addr_o[5:0]];
        if (rd_req_o) reads_seen <= reads_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int region_size(input int r);
        case (r)
            0: return MAINW;
            1: return INFOW;
            3: return ENGW;
            default: return 0;
        endcase
    endfunction

    task automatic model(input int r, input int pat, input int hlt, input int b, input int l);
        int sz;
        sz = region_size(r);
        e_reads = 0; e_cnt = 0; e_faddr = 0; e_cmp = 0; e_aerr = 0; e_halt = 0;
        for (int i = 0; i < l; i++) begin
            int a;
            a = b + i;
            if (a >= sz) begin
                e_aerr = 1;
                break;
            end
            e_reads++;
            if (mem[r][a] != (pat != 0 ? 8'hFF : 8'h00)) begin
                if (e_cnt == 0) e_faddr = a;
                e_cmp = 1;
                if (e_cnt < 15) e_cnt++;   // R4 saturation at 2^CW-1
                if (hlt != 0) begin
                    e_halt = 1;
                    break;
                end
            end
        end
        e_lat = (e_halt != 0) ? 2 * e_reads + 2 : 2 * e_reads + 3;
    endtask

    task automatic set_cfg(input int b, input int l);
        @(negedge clk);
        base_we_i  = 1'b1; base_i  = AW'(b);
        count_we_i = 1'b1; count_i = LW'(l);
        @(negedge clk);
        base_we_i  = 1'b0;
        count_we_i = 1'b0;
    endtask

    // start at a falling edge, return edges counted until status 3
    task automatic launch(input int r, input int pat, input int hlt, output int n, output int st1);
        region_i  = 2'(r);
        pattern_i = pat[0];
        halt_i    = hlt[0];
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n   = 1;
        st1 = int'(status_o);
        while (status_o != 2'd3 && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_one(input int r, input int pat, input int hlt, input int b, input int l);
        int n, st1, r0;
        string rtag;
        set_cfg(b, l);
        model(r, pat, hlt, b, l);
        r0 = reads_seen;
        launch(r, pat, hlt, n, st1);
        rtag = (l == 0) ? "R8" : ((hlt != 0) ? "R6" : "R2");
        chk(st1 == 1, "R1", "status after start edge", st1, 1);
        chk(n == e_lat, rtag, "edges to finish", n, e_lat);
        chk(reads_seen - r0 == e_reads, rtag, "read count", reads_seen - r0, e_reads);
        chk(int'(cmp_err_o) == e_cmp, "R3", "compare error", int'(cmp_err_o), e_cmp);
        chk(int'(fail_cnt_o) == e_cnt, "R4", "fail count", int'(fail_cnt_o), e_cnt);
        chk(int'(fail_addr_o) == e_faddr, "R5", "fail address", int'(fail_addr_o), e_faddr);
        chk(int'(addr_err_o) == e_aerr, "R7", "address error", int'(addr_err_o), e_aerr);
        chk(done_flag_o == 1'b1, "R11", "completion flag", int'(done_flag_o), 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        nfail++;
        $display("FAIL watchdog R1: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int n, st1, r0, sz, bb;
        for (int r = 0; r < 4; r++) begin
            for (int a = 0; a < 64; a++) begin
                case (a % 5)
                    0, 1:    mem[r][a] = 8'h00;
                    2, 3:    mem[r][a] = 8'hFF;
                    default: mem[r][a] = 8'h5A;
                endcase
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_o == 2'd0, "R1", "reset status", int'(status_o), 0);
        chk(!cmp_err_o && !addr_err_o, "R9", "reset error bits", int'({cmp_err_o, addr_err_o}), 0);
        chk(fail_cnt_o == '0, "R4", "reset fail count", int'(fail_cnt_o), 0);
        chk(!done_flag_o && !rd_req_o, "R11", "reset flag and request", int'({done_flag_o, rd_req_o}), 0);

        // sweep region x pattern x halt x window
        for (int r = 0; r < 4; r++) begin
            sz = region_size(r);
            for (int pat = 0; pat < 2; pat++) begin
                for (int hlt = 0; hlt < 2; hlt++) begin
                    for (int w = 0; w < 4; w++) begin
                        bb = (sz >= 3) ? sz - 3 : 0;
                        case (w)
                            0: run_one(r, pat, hlt, 0, 0);
                            1: run_one(r, pat, hlt, 1, 6);
                            2: run_one(r, pat, hlt, bb, 6);
                            default: run_one(r, pat, hlt, 0, (sz > 0) ? sz : 4);
                        endcase
                    end
                end
            end
        end

        // R9: finished state persists, clear returns to idle
        run_one(0, 1, 0, 0, 5);
        repeat (10) @(negedge clk);
        chk(status_o == 2'd3, "R9", "status held", int'(status_o), 3);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk(status_o == 2'd0, "R9", "status after clear", int'(status_o), 0);
        chk(!cmp_err_o && !addr_err_o, "R9", "errors after clear", int'({cmp_err_o, addr_err_o}), 0);
        chk(!done_flag_o, "R9", "flag after clear", int'(done_flag_o), 0);

        // R10: writes and start ignored while scanning
        set_cfg(0, 4);
        r0 = reads_seen;
        region_i = 2'd0; pattern_i = 1'b1; halt_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        base_we_i = 1'b1; base_i = 8'd10; count_we_i = 1'b1; count_i = 8'd30; start_i = 1'b1;
        @(negedge clk);
        base_we_i = 1'b0; count_we_i = 1'b0; start_i = 1'b0;
        chk(status_o == 2'd2, "R10", "status after start while scanning", int'(status_o), 2);
        n = 0;
        while (status_o != 2'd3 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(reads_seen - r0 == 4, "R10", "reads with ignored count write", reads_seen - r0, 4);
        r0 = reads_seen;
        launch(0, 1, 0, n, st1);
        chk(reads_seen - r0 == 4, "R10", "reads on rerun with old count", reads_seen - r0, 4);
        chk(n == 11, "R10", "rerun edges with old count", n, 11);
        model(0, 1, 0, 0, 4);
        chk(int'(fail_addr_o) == e_faddr, "R10", "rerun used old base", int'(fail_addr_o), e_faddr);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule